// File: doc/BRIEF.md
# Disk Sector Record Generator

This block assembles one complete 288-byte disk sector record and sends it out as a byte stream with a valid/ready handshake. A one-cycle start pulse supplies a cylinder, head and sector address. The block then emits, in a fixed order, the leading sync bytes, a packed address field and its CRC-16, a gap, a second sync run, the 256 payload bytes pulled from an upstream byte stream, the CRC-16 of the payload, and a trailing run of zero bytes.

Both CRC fields use the same reflected CRC-16 engine. One record is special. On the final track of the medium, the upstream payload is not consumed. A fixed image of an empty defect table is inserted in its place, and the data CRC is computed over that image.

An address outside the medium's geometry produces no record. The block raises an error flag and waits for the next start.

Top module: `sector_record_gen`

## Requirements
- R1: Within a record, the byte positions that carry fixed values have these values: bytes 0–2 are 0x00 and byte 3 is 0x80; bytes 6–7 and 10–16 are 0x00 and byte 17 is 0x80; bytes 276–287 are 0x00.
- R2: Byte 4 is {cyl[0], head, sector[5:0]} (bit 7 down to bit 0). Byte 5 is cyl[8:1].
- R3: Bytes 8 (low half) and 9 (high half) carry a reflected CRC-16 (polynomial 0xA001, start value 0, data taken LSB first) over bytes 4–7 only.
- R4: Bytes 18–273 are the payload in arrival order. Bytes 274 (low half) and 275 (high half) carry the same CRC over those 256 bytes only.
- R5: `pl_ready` is high only while the record is at a payload position (18–273). One payload byte is consumed per accepted output byte in that window.
- R6: `done` is high for exactly one cycle, in the cycle after byte 287 is accepted, and `out_valid` is low from then until the next start.
- R7: A start with cylinder ≥ 512 or sector ≥ 40 sets `err` and emits nothing (`out_valid` and `pl_ready` stay low). The next in-range start clears `err`.
- R8: On the last track (cylinder 511, head 1), `pl_ready` stays low and upstream data has no effect. Payload bytes are 0x03, 0x28, 0x54, 0x19, four 0x00, then 248 bytes of 0xFF. The data CRC covers these bytes.
- R9: While `out_valid` is high and `out_ready` is low, the record position does not advance, so no byte is lost or repeated.
- R10: A start pulse while a record is in progress is ignored. The current record completes unchanged.
- R11: After reset, `out_valid`, `pl_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that latches the address and begins a record |
| cyl | input | 10 | Cylinder number |
| head | input | 1 | Head (surface) number |
| sector | input | 6 | Sector number |
| pl_data | input | 8 | Payload byte from upstream |
| pl_valid | input | 1 | Upstream payload byte is valid |
| pl_ready | output | 1 | Block accepts the payload byte this cycle |
| out_data | output | 8 | Record byte |
| out_valid | output | 1 | Record byte is valid |
| out_ready | input | 1 | Downstream accepts the record byte |
| done | output | 1 | One-cycle pulse after the last record byte |
| err | output | 1 | Last start carried an out-of-range address |

## Verification
The bench targets the corner cases of this block and checks what an error in each would look like.

- **Last-track boundary.** The bench runs cylinder 511 with head 1 and with head 0. A wrong last-track compare either passes upstream data through or pulls the fill pattern into an ordinary record. In both cases the data CRC is also wrong.
- **CRC clearing.** The address CRC and data CRC are checked in every record. A CRC register that is not cleared between the two fields corrupts bytes 274–275. A byte-order swap corrupts both CRC pairs.
- **Backpressure.** Random stalls on both sides check that a counter advancing during a stall shows up as a shifted or duplicated byte.
- **Stray start and bad addresses.** A start pulse injected mid-record checks that the record is not restarted. Out-of-range addresses must leave the output silent with `err` set.

// File: rtl/srg_pkg.sv
// Shared constants and the CRC step for the sector record generator.
// Assumes a byte-wide stream and a fixed 288-byte record layout.
package srg_pkg;
    parameter int BYTE_W   = 8;
    parameter int REC_LEN  = 288;
    parameter int ADDR_OFS = 4;
    parameter int ADDR_LEN = 4;
    parameter int PAY_OFS  = 18;
    parameter int PAY_LEN  = 256;
    parameter int IDX_W    = $clog2(REC_LEN);
    parameter int ACRC_OFS = ADDR_OFS + ADDR_LEN;
    parameter int DCRC_OFS = PAY_OFS + PAY_LEN;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Reflected CRC-16 (0xA001) update over one byte, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input byte_t d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/srg_crc16.sv
// CRC-16 accumulator shared by the address and data fields.
// Assumes clr and en are never both needed in one cycle; clr wins.
module srg_crc16
    import srg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  byte_t       din,
    output logic [15:0] crc
);
    // Clear or fold one accepted byte into the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc16_step(crc, din);
    end

    // R3: a clear always leaves a zero start value
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> crc == 16'h0000);
    // R4: the CRC moves only on a covered, accepted byte
    a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/srg_fill.sv
// Fixed payload image used on the last track: an empty defect table.
// Input k is the payload offset (record position minus payload start).
module srg_fill
    import srg_pkg::*;
(
    input  idx_t  k,
    output byte_t fill
);
    // Map payload offset to the fixed table byte.
    always_comb begin
        if      (k == idx_t'(0)) fill = 8'h03;
        else if (k == idx_t'(1)) fill = 8'h28;
        else if (k == idx_t'(2)) fill = 8'h54;
        else if (k == idx_t'(3)) fill = 8'h19;
        else if (k <  idx_t'(8)) fill = 8'h00;
        else                     fill = 8'hFF;
    end
endmodule

// File: rtl/srg_ctrl.sv
// Record sequencer: tracks the byte position, busy, done and error state.
// Assumes adv is asserted only when an output byte is accepted.
module srg_ctrl
    import srg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic addr_ok,
    input  logic adv,
    output logic busy,
    output idx_t idx,
    output logic done,
    output logic err
);
    localparam idx_t LAST_IDX = idx_t'(REC_LEN - 1);

    // Start, advance and finish a record; flag bad addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= addr_ok;
                    err  <= !addr_ok;
                    idx  <= '0;
                end
            end else if (adv) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + idx_t'(1);
                end
            end
        end
    end

    // R6: position never leaves the record
    a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idx <= LAST_IDX);
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: an error never coexists with a running record
    a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: rtl/sector_record_gen.sv
// Sector record generator top: latches the address, steps through the
// 288-byte layout, and muxes sync bytes, address, CRCs and payload.
// Assumes upstream holds pl_data while pl_valid is high and pl_ready is low.
module sector_record_gen
    import srg_pkg::*;
#(
    parameter int CYL_W     = 10,
    parameter int SEC_W     = 6,
    parameter int CYL_COUNT = 512,
    parameter int SEC_COUNT = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CYL_W-1:0] cyl,
    input  logic             head,
    input  logic [SEC_W-1:0] sector,
    input  logic [7:0]       pl_data,
    input  logic             pl_valid,
    output logic             pl_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             done,
    output logic             err
);
    localparam idx_t I_SYNC1  = idx_t'(3);
    localparam idx_t I_A0     = idx_t'(ADDR_OFS);
    localparam idx_t I_A1     = idx_t'(ADDR_OFS + 1);
    localparam idx_t I_AEND   = idx_t'(ACRC_OFS);
    localparam idx_t I_ACRCH  = idx_t'(ACRC_OFS + 1);
    localparam idx_t I_SYNC2  = idx_t'(PAY_OFS - 1);
    localparam idx_t I_PAY    = idx_t'(PAY_OFS);
    localparam idx_t I_DCRC   = idx_t'(DCRC_OFS);
    localparam idx_t I_DCRCH  = idx_t'(DCRC_OFS + 1);

    logic             busy, adv, addr_ok, in_addr, in_pay, last_trk;
    idx_t             idx, k;
    logic [CYL_W-1:0] a_cyl;
    logic             a_head;
    logic [SEC_W-1:0] a_sec;
    logic [15:0]      crc;
    byte_t            fill, pay_byte;
    logic             crc_clr, crc_en;

    assign addr_ok = (cyl < CYL_W'(CYL_COUNT)) && (sector < SEC_W'(SEC_COUNT));

    // Latch the address on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cyl  <= '0;
            a_head <= 1'b0;
            a_sec  <= '0;
        end else if (start && !busy) begin
            a_cyl  <= cyl;
            a_head <= head;
            a_sec  <= sector;
        end
    end

    srg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_ok(addr_ok),
        .adv(adv), .busy(busy), .idx(idx), .done(done), .err(err)
    );

    // Decode the record phase and the handshakes.
    always_comb begin
        in_addr   = (idx >= I_A0)  && (idx < I_AEND);
        in_pay    = (idx >= I_PAY) && (idx < I_DCRC);
        last_trk  = (a_cyl == CYL_W'(CYL_COUNT - 1)) && a_head;
        out_valid = busy && (!in_pay || last_trk || pl_valid);
        pl_ready  = busy && in_pay && !last_trk && out_ready;
        adv       = out_valid && out_ready;
        k         = idx - I_PAY;
    end

    srg_fill u_fill (.k(k), .fill(fill));

    assign pay_byte = last_trk ? fill : pl_data;
    assign crc_clr  = !busy || (adv && idx == I_ACRCH);
    assign crc_en   = adv && (in_addr || in_pay);

    srg_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(out_data), .crc(crc)
    );

    // Select the byte for the current record position.
    always_comb begin
        out_data = 8'h00;
        if (idx == I_SYNC1 || idx == I_SYNC2)  out_data = 8'h80;
        else if (idx == I_A0)                  out_data = {a_cyl[0], a_head, a_sec[5:0]};
        else if (idx == I_A1)                  out_data = a_cyl[8:1];
        else if (idx == I_AEND || idx == I_DCRC)  out_data = crc[7:0];
        else if (idx == I_ACRCH || idx == I_DCRCH) out_data = crc[15:8];
        else if (in_pay)                       out_data = pay_byte;
    end

    // R9: a stalled non-payload byte is held with valid still high
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && out_valid && !out_ready && !in_pay) |=> (out_valid && $stable(out_data)));
    // R8: no payload is requested on the last track
    a_r8_fill_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_trk) |-> !pl_ready);
    // R7: an error leaves the output silent
    a_r7_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && !pl_ready));
    // R5: a payload request only ever comes with an accepted output byte
    a_r5_req_window: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> (busy && out_ready));
endmodule

// File: tb/sim_sector_record_gen.sv
module sim_sector_record_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] cyl = '0;
    logic       head = 1'b0;
    logic [5:0] sector = '0;
    logic [7:0] pl_data = '0;
    logic       pl_valid = 1'b0;
    logic       pl_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       done, err;

    int total = 0;
    int bad = 0;

    logic [7:0] pay [256];
    logic [7:0] expv [288];
    logic [7:0] got [288];

    always #10 clk = ~clk;

    sector_record_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cyl(cyl), .head(head),
        .sector(sector), .pl_data(pl_data), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .done(done), .err(err)
    );

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input string what);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    task automatic build_exp(input int c, input int h, input int s, input bit lastt);
        logic [15:0] cr;
        for (int i = 0; i < 288; i++) expv[i] = 8'h00;
        expv[3] = 8'h80;
        expv[17] = 8'h80;
        expv[4] = {c[0], h[0], s[5:0]};
        expv[5] = c[8:1];
        cr = 16'h0;
        for (int i = 4; i < 8; i++) cr = bcrc(cr, expv[i]);
        expv[8] = cr[7:0];
        expv[9] = cr[15:8];
        for (int i = 0; i < 256; i++) begin
            if (lastt) expv[18+i] = (i == 0) ? 8'h03 : (i == 1) ? 8'h28 : (i == 2) ? 8'h54 :
                                    (i == 3) ? 8'h19 : (i < 8) ? 8'h00 : 8'hFF;
            else expv[18+i] = pay[i];
        end
        cr = 16'h0;
        for (int i = 18; i < 274; i++) cr = bcrc(cr, expv[i]);
        expv[274] = cr[7:0];
        expv[275] = cr[15:8];
    endtask

    task automatic seg_check(input string req, input int lo, input int hi, input string what);
        int mism;
        int first;
        mism = 0;
        first = -1;
        for (int i = lo; i <= hi; i++) begin
            if (got[i] !== expv[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s %s: byte %0d actual=%0h expected=%0h", req, what, first, got[first], expv[first]);
        end
    endtask

    task automatic run_rec(input int c, input int h, input int s, input int stall, input bit inject);
        int n;
        int pidx;
        int guard;
        bit lastt;
        bit req_bad;
        lastt = (c == 511) && (h == 1);
        for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
        build_exp(c, h, s, lastt);
        @(negedge clk);
        cyl = 10'(c); head = h[0]; sector = 6'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; pidx = 0; guard = 0; req_bad = 0;
        while (n < 288 && guard < 6000) begin
            out_ready = ($urandom_range(99) >= stall);
            pl_valid  = ($urandom_range(99) >= stall);
            pl_data   = lastt ? 8'($urandom) : ((pidx < 256) ? pay[pidx] : 8'h00);
            start     = inject && (n == 100);
            if (inject && n == 100) begin cyl = 10'd3; head = 1'b0; sector = 6'd2; end
            #1;
            if (pl_ready && (n < 18 || n >= 274)) req_bad = 1;
            if (pl_ready && lastt) req_bad = 1;
            if (pl_ready && pl_valid) pidx++;
            if (out_valid && out_ready) begin
                got[n] = out_data;
                n++;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0; out_ready = 1'b0; pl_valid = 1'b0;
        #1;
        check("R6", done, 1, "done after last byte");
        check("R6", out_valid, 0, "valid low after record");
        check("R9", n, 288, "bytes received under stalls");
        seg_check("R1", 0, 3, "leading sync");
        seg_check("R1", 6, 7, "address pad");
        seg_check("R1", 10, 17, "gap and second sync");
        seg_check("R1", 276, 287, "trailer");
        seg_check("R2", 4, 5, "address bytes");
        seg_check("R3", 8, 9, "address CRC");
        if (lastt) begin
            seg_check("R8", 18, 273, "fill payload");
            seg_check("R8", 274, 275, "fill data CRC");
            check("R8", req_bad, 0, "payload requested on last track");
        end else begin
            seg_check("R4", 18, 273, "payload");
            seg_check("R4", 274, 275, "data CRC");
            check("R5", req_bad, 0, "pl_ready outside payload");
            check("R5", pidx, 256, "payload bytes consumed");
        end
        if (inject) check("R10", got[4], int'(expv[4]), "address after stray start");
        @(negedge clk);
        #1;
        check("R6", done, 0, "done pulse width");
    endtask

    task automatic bad_start(input int c, input int s);
        int seen;
        @(negedge clk);
        cyl = 10'(c); head = 1'b1; sector = 6'(s); start = 1'b1; out_ready = 1'b1; pl_valid = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            #1;
            if (out_valid || pl_ready) seen++;
            @(negedge clk);
        end
        check("R7", err, 1, "err on out-of-range address");
        check("R7", seen, 0, "output active after bad address");
        out_ready = 1'b0; pl_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11", out_valid, 0, "reset out_valid");
        check("R11", pl_ready, 0, "reset pl_ready");
        check("R11", done, 0, "reset done");
        check("R11", err, 0, "reset err");
        run_rec(0, 0, 0, 0, 0);
        run_rec(511, 1, 39, 30, 0);
        run_rec(511, 1, 0, 0, 0);
        run_rec(511, 0, 39, 30, 0);
        run_rec(256, 1, 17, 20, 1);
        bad_start(100, 40);
        bad_start(512, 5);
        bad_start(1023, 63);
        run_rec(1, 0, 1, 40, 0);
        check("R7", err, 0, "err cleared by valid start");
        for (int r = 0; r < 6; r++) begin
            run_rec(int'($urandom_range(510)), int'($urandom_range(1)), int'($urandom_range(39)), 35, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule